// File: doc/BRIEF.md
# Strobed Multiplexed I/O Port

This block owns twelve shared I/O pins that several channels take turns on. Each channel has an active-low strobe input and a 12-bit data register. While a channel holds its strobe low, every pin that the direction register marks as an output drives the matching bit of that channel's register. Every pin marked as an input is copied into the same register, so one register carries data both ways. A single direction mask covers all channels. The strobe sequencer that scans the channels sits outside; the strobes reach this block as plain inputs.

A mode bit switches the port to static operation. The strobe pins stop acting as strobes and become four extra general-purpose pins, each with its own direction bit. Those pins are driven from, or captured into, bits 3..0 of channel 2's register. A host reads and writes every register through a byte-wide interface with a combinational read port and a single-cycle write strobe.

All pin and strobe inputs pass through a synchronizer before the logic uses them. If more than one strobe is low at once, the lowest-numbered channel gets the pins. A host write to a register bit beats a pin capture into that bit in the same cycle.

Top module: `strobe_io_port`

## Requirements
- R1: After reset every data register, the direction register and the configuration register read 00h. The port is in strobed mode, and `pin_oe` and `strb_oe` are all zero.
- R2: Register map. 00h is configuration: bit 4 selects the mode (0 strobed, 1 static) and bits 3..0 set the strobe-pin directions (1 output). Channel n keeps bits 7..0 at 02h+2n and bits 11..8 in the low nibble of 03h+2n; the upper nibble of that byte reads 0. The direction mask sits at 0Ah (bits 7..0) and 0Bh (bits 11..8). Every other address reads 00h and ignores writes.
- R3: In strobed mode with a synchronized strobe low, `pin_oe` equals the direction mask and `pin_o` carries the granted channel's register on those bits.
- R4: In strobed mode, each cycle the granted strobe is low, pins whose direction bit is 0 are written into the granted channel's register. Bits whose direction is output keep their value.
- R5: In strobed mode with no synchronized strobe low, `pin_oe` is zero and no register captures pin data.
- R6: When several strobes are low, only the lowest-numbered channel drives the pins and captures.
- R7: Pin and strobe inputs pass through two flops. A strobe that falls before clock edge k shows up on `pin_oe` after edge k+1.
- R8: A host write to a register byte in the same cycle as a capture into that byte leaves the written value.
- R9: In static mode `pin_oe` is zero and strobes cause no capture. Strobe pin k with direction bit 1 has `strb_oe[k]`=1 and `strb_o[k]` equal to bit k of channel 2. With direction bit 0, its synchronized level is written into bit k of channel 2 every cycle.
- R10: In strobed mode `strb_oe` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write strobe for one cycle |
| addr | input | 8 | Host register address |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Host read data, combinational on addr |
| pin_i | input | 12 | Shared pin input levels |
| pin_o | output | 12 | Shared pin output values |
| pin_oe | output | 12 | Shared pin output enables, 1 drives |
| strb_i | input | 4 | Channel strobes, active low; static-mode pin inputs |
| strb_o | output | 4 | Strobe-pin output values in static mode |
| strb_oe | output | 4 | Strobe-pin output enables in static mode |

## Verification
The grant assertions assume that strobe inputs hold steady long enough to pass the synchronizer, so that the registered grant follows one coherent strobe pattern. The stimulus therefore changes strobes and pins only on falling clock edges and holds each pattern for several cycles. The host-priority assertions assume a write lasts exactly one cycle. The bench drives `wr_en` for one cycle per access, including the write that overlaps a live capture. Static-mode checks assume the bench's strobe-pin levels are ignored on pins set as outputs, so the stimulus drives arbitrary levels there as well.

// File: rtl/sio_pkg.sv
package sio_pkg;
   typedef enum logic {
      MODE_STROBED = 1'b0,
      MODE_STATIC  = 1'b1
   } sio_mode_e;

   localparam int BYTE_W   = 8;
   localparam int CFG_ADDR = 0;
   localparam int CH_BASE  = 2;
   localparam int MODE_BIT = 4;
endpackage

// File: rtl/sio_sync.sv
module sio_sync #(
   parameter int            W       = 12,
   parameter int            STAGES  = 2,
   parameter logic [W-1:0]  RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] stage_q [STAGES];

   if (STAGES < 2) begin : g_bad_stages
      $error("sio_sync: STAGES must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) stage_q[s] <= RST_VAL;
      end else begin
         stage_q[0] <= d;
         for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
      end
   end

   assign q = stage_q[STAGES-1];
endmodule

// File: rtl/sio_prio_arb.sv
module sio_prio_arb #(
   parameter int N = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] req_n,
   output logic [N-1:0] grant,
   output logic         any
);
   logic [N-1:0] active;
   logic [N:0]   lower;

   assign active   = ~req_n;
   assign lower[0] = 1'b0;

   for (genvar i = 0; i < N; i++) begin : g_chain
      assign grant[i]   = active[i] & ~lower[i];
      assign lower[i+1] = lower[i] | active[i];
   end

   assign any = lower[N];

   AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant)); // R6
   AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      !req_n[0] |-> grant[0]); // R6
   AST_GRANT_WHEN_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (req_n != '1) |-> ($countones(grant) == 1)); // R6
endmodule

// File: rtl/sio_chan_reg.sv
module sio_chan_reg
   import sio_pkg::*;
#(
   parameter int W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_lo,
   input  logic              wr_hi,
   input  logic [BYTE_W-1:0] wdata,
   input  logic [W-1:0]      cap_mask,
   input  logic [W-1:0]      cap_val,
   output logic [W-1:0]      q
);
   localparam int HI_W = W - BYTE_W;

   logic [W-1:0] nxt;

   always_comb begin
      // pin capture first, host write laid over it (R8)
      nxt = (q & ~cap_mask) | (cap_val & cap_mask);
      if (wr_lo) nxt[BYTE_W-1:0] = wdata;
      if (wr_hi) nxt[W-1:BYTE_W] = wdata[HI_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0; // R1
      else        q <= nxt;
   end

   AST_HOST_WINS_LO: assert property (@(posedge clk) disable iff (!rst_n)
      wr_lo |=> (q[BYTE_W-1:0] == $past(wdata))); // R8
   AST_HOST_WINS_HI: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hi |=> (q[W-1:BYTE_W] == $past(wdata[HI_W-1:0]))); // R8
   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_lo && !wr_hi && cap_mask == '0) |=> $stable(q)); // R5
endmodule

// File: rtl/strobe_io_port.sv
module strobe_io_port
   import sio_pkg::*;
#(
   parameter int NUM_CH      = 4,
   parameter int PIN_W       = 12,
   parameter int ADDR_W      = 8,
   parameter int STATIC_CH   = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [7:0]        wdata,
   output logic [7:0]        rdata,
   input  logic [PIN_W-1:0]  pin_i,
   output logic [PIN_W-1:0]  pin_o,
   output logic [PIN_W-1:0]  pin_oe,
   input  logic [NUM_CH-1:0] strb_i,
   output logic [NUM_CH-1:0] strb_o,
   output logic [NUM_CH-1:0] strb_oe
);
   localparam int HI_W     = PIN_W - BYTE_W;
   localparam int DIR_ADDR = CH_BASE + 2 * NUM_CH;

   // elaboration checks on the parameter set
   if (NUM_CH < 2 || NUM_CH > MODE_BIT) begin : g_bad_ch
      $error("strobe_io_port: NUM_CH must lie in 2..4");
   end
   if (PIN_W <= BYTE_W || PIN_W > 2 * BYTE_W) begin : g_bad_pin
      $error("strobe_io_port: PIN_W must lie in 9..16");
   end
   if (STATIC_CH >= NUM_CH) begin : g_bad_static
      $error("strobe_io_port: STATIC_CH must name an existing channel");
   end
   if (DIR_ADDR + 1 >= (1 << ADDR_W)) begin : g_bad_addr
      $error("strobe_io_port: register map does not fit ADDR_W");
   end

   // synchronized inputs (R7); strobes reset inactive
   logic [PIN_W-1:0]  s_pin;
   logic [NUM_CH-1:0] s_strb;

   sio_sync #(.W(PIN_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) i_pin_sync (
      .clk(clk), .rst_n(rst_n), .d(pin_i), .q(s_pin));

   sio_sync #(.W(NUM_CH), .STAGES(SYNC_STAGES), .RST_VAL('1)) i_strb_sync (
      .clk(clk), .rst_n(rst_n), .d(strb_i), .q(s_strb));

   // configuration and direction registers
   sio_mode_e         mode_q;
   logic [NUM_CH-1:0] sdir_q;
   logic [PIN_W-1:0]  dir_q;

   logic cfg_wr, dir_lo_wr, dir_hi_wr;
   assign cfg_wr    = wr_en && (addr == ADDR_W'(CFG_ADDR));
   assign dir_lo_wr = wr_en && (addr == ADDR_W'(DIR_ADDR));
   assign dir_hi_wr = wr_en && (addr == ADDR_W'(DIR_ADDR + 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= MODE_STROBED; // R1
         sdir_q <= '0;
         dir_q  <= '0;
      end else begin
         if (cfg_wr) begin
            mode_q <= sio_mode_e'(wdata[MODE_BIT]);
            sdir_q <= wdata[NUM_CH-1:0];
         end
         if (dir_lo_wr) dir_q[BYTE_W-1:0]     <= wdata;
         if (dir_hi_wr) dir_q[PIN_W-1:BYTE_W] <= wdata[HI_W-1:0];
      end
   end

   // strobe arbitration (R6)
   logic [NUM_CH-1:0] grant;
   logic              any_strb;

   sio_prio_arb #(.N(NUM_CH)) i_arb (
      .clk(clk), .rst_n(rst_n), .req_n(s_strb), .grant(grant), .any(any_strb));

   logic strobed;
   assign strobed = (mode_q == MODE_STROBED);

   // per-channel data registers
   logic [PIN_W-1:0] chq  [NUM_CH];
   logic [PIN_W-1:0] term [NUM_CH];

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic             wr_lo, wr_hi;
      logic [PIN_W-1:0] cap_mask, cap_val;

      assign wr_lo = wr_en && (addr == ADDR_W'(CH_BASE + 2 * c));
      assign wr_hi = wr_en && (addr == ADDR_W'(CH_BASE + 2 * c + 1));

      if (c == STATIC_CH) begin : g_static_host
         // this channel also serves the strobe pins in static mode (R9)
         always_comb begin
            cap_mask = '0;
            cap_val  = s_pin;
            if (strobed) begin
               if (grant[c]) cap_mask = ~dir_q;
            end else begin
               cap_mask[NUM_CH-1:0] = ~sdir_q;
               cap_val[NUM_CH-1:0]  = s_strb;
            end
         end
      end else begin : g_plain
         assign cap_mask = (strobed && grant[c]) ? ~dir_q : '0; // R4
         assign cap_val  = s_pin;
      end

      sio_chan_reg #(.W(PIN_W)) i_reg (
         .clk(clk), .rst_n(rst_n), .wr_lo(wr_lo), .wr_hi(wr_hi),
         .wdata(wdata), .cap_mask(cap_mask), .cap_val(cap_val), .q(chq[c]));

      assign term[c] = grant[c] ? chq[c] : '0;
   end

   // pin drive (R3, R5, R9)
   always_comb begin
      pin_o = '0;
      for (int c = 0; c < NUM_CH; c++) pin_o = pin_o | term[c];
   end

   assign pin_oe  = (strobed && any_strb) ? dir_q : '0;
   assign strb_o  = chq[STATIC_CH][NUM_CH-1:0];
   assign strb_oe = strobed ? '0 : sdir_q; // R10

   // host read port (R2)
   always_comb begin
      rdata = '0;
      if (addr == ADDR_W'(CFG_ADDR)) begin
         rdata[MODE_BIT]     = (mode_q == MODE_STATIC);
         rdata[NUM_CH-1:0]   = sdir_q;
      end
      for (int c = 0; c < NUM_CH; c++) begin
         if (addr == ADDR_W'(CH_BASE + 2 * c))     rdata = chq[c][BYTE_W-1:0];
         if (addr == ADDR_W'(CH_BASE + 2 * c + 1)) rdata[HI_W-1:0] = chq[c][PIN_W-1:BYTE_W];
      end
      if (addr == ADDR_W'(DIR_ADDR))     rdata = dir_q[BYTE_W-1:0];
      if (addr == ADDR_W'(DIR_ADDR + 1)) rdata[HI_W-1:0] = dir_q[PIN_W-1:BYTE_W];
   end

   AST_STATIC_DATA_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MODE_STATIC) |-> (pin_oe == '0)); // R9
   AST_IDLE_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
      (strobed && (s_strb == '1)) |-> (pin_oe == '0)); // R5
   AST_STROBED_NO_STRB_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
      strobed |-> (strb_oe == '0)); // R10
   AST_OE_INSIDE_DIR: assert property (@(posedge clk) disable iff (!rst_n)
      ((pin_oe & ~dir_q) == '0)); // R3
endmodule

// File: tb/test_strobe_io_port.sv
module test_strobe_io_port;
   localparam int NCH = 4;
   localparam int PW  = 12;
   localparam int SCH = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic          wr_en = 1'b0;
   logic [7:0]    addr  = '0;
   logic [7:0]    wdata = '0;
   wire  [7:0]    rdata;
   logic [PW-1:0] pin_i = '0;
   wire  [PW-1:0] pin_o, pin_oe;
   logic [NCH-1:0] strb_i = '1;
   wire  [NCH-1:0] strb_o, strb_oe;

   strobe_io_port i_strobe_io_port (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .rdata(rdata), .pin_i(pin_i), .pin_o(pin_o), .pin_oe(pin_oe),
      .strb_i(strb_i), .strb_o(strb_o), .strb_oe(strb_oe));

   int errors = 0;
   int checks = 0;
   bit done   = 1'b0;

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // behavioural reference model
   logic [PW-1:0]  m_reg [NCH];
   logic [PW-1:0]  n_reg [NCH];
   logic [PW-1:0]  m_dir = '0;
   logic           m_mode = 1'b0;
   logic [NCH-1:0] m_sdir = '0;
   logic [PW-1:0]  m_p1 = '0, m_p2 = '0;
   logic [NCH-1:0] m_s1 = '1, m_s2 = '1;
   int             m_w, m_c, m_a;

   initial for (int c = 0; c < NCH; c++) m_reg[c] = '0;

   function automatic int lowest(input logic [NCH-1:0] s);
      for (int c = 0; c < NCH; c++) if (!s[c]) return c;
      return -1;
   endfunction

   function automatic logic [7:0] model_rd(input logic [7:0] a);
      int ai;
      ai = int'(a);
      if (ai == 0) return {3'b000, m_mode, m_sdir};
      if (ai >= 2 && ai < 2 + 2 * NCH) begin
         if (ai % 2 == 0) return m_reg[(ai - 2) / 2][7:0];
         return {4'h0, m_reg[(ai - 2) / 2][11:8]};
      end
      if (ai == 2 + 2 * NCH) return m_dir[7:0];
      if (ai == 3 + 2 * NCH) return {4'h0, m_dir[11:8]};
      return 8'h00;
   endfunction

   task automatic compare();
      int w;
      logic [PW-1:0] exp_oe;
      w = lowest(m_s2);
      exp_oe = (!m_mode && w >= 0) ? m_dir : '0;
      chk(m_mode ? "R9" : (w >= 0 ? "R3" : "R5"), "pin_oe", pin_oe, exp_oe);
      if (w >= 0 && !m_mode) chk("R3", "pin_o", pin_o & exp_oe, m_reg[w] & exp_oe);
      chk(m_mode ? "R9" : "R10", "strb_oe", strb_oe, m_mode ? m_sdir : '0);
      if (m_mode) chk("R9", "strb_o", strb_o & m_sdir, m_reg[SCH][NCH-1:0] & m_sdir);
      chk("R2", "rdata", rdata, model_rd(addr));
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int c = 0; c < NCH; c++) m_reg[c] = '0;
         m_dir = '0; m_mode = 1'b0; m_sdir = '0;
         m_p1 = '0; m_p2 = '0; m_s1 = '1; m_s2 = '1;
      end else begin
         for (int c = 0; c < NCH; c++) n_reg[c] = m_reg[c];
         m_w = lowest(m_s2);
         if (!m_mode && m_w >= 0)
            for (int i = 0; i < PW; i++) if (!m_dir[i]) n_reg[m_w][i] = m_p2[i];
         if (m_mode)
            for (int k = 0; k < NCH; k++) if (!m_sdir[k]) n_reg[SCH][k] = m_s2[k];
         if (wr_en) begin
            m_a = int'(addr);
            if (m_a == 0) begin
               m_mode = wdata[4];
               m_sdir = wdata[NCH-1:0];
            end else if (m_a >= 2 && m_a < 2 + 2 * NCH) begin
               m_c = (m_a - 2) / 2;
               if (m_a % 2 == 0) n_reg[m_c][7:0] = wdata;
               else              n_reg[m_c][11:8] = wdata[3:0];
            end else if (m_a == 2 + 2 * NCH) m_dir[7:0] = wdata;
            else if (m_a == 3 + 2 * NCH)     m_dir[11:8] = wdata[3:0];
         end
         for (int c = 0; c < NCH; c++) m_reg[c] = n_reg[c];
         m_p2 = m_p1; m_p1 = pin_i;
         m_s2 = m_s1; m_s1 = strb_i;
      end
      #5;
      if (rst_n && !done) compare();
   end

   task automatic wait_cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd_chk(input string req, input logic [7:0] a, input logic [7:0] exp);
      @(negedge clk);
      addr = a;
      @(posedge clk);
      #5;
      chk(req, $sformatf("read %h", a), rdata, exp);
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      #(200000 * 20);
      errors++;
      checks++;
      $display("FAIL watchdog: actual running expected finished");
      finish_run();
   end

   initial begin
      wait_cyc(3);
      rst_n = 1'b1;
      // R1: reset state
      for (int a = 0; a < 12; a++) rd_chk("R1", 8'(a), 8'h00);
      chk("R1", "pin_oe", pin_oe, 12'h000);
      chk("R1", "strb_oe", strb_oe, 4'h0);

      // R2: map, upper nibble, unmapped
      wr(8'h0A, 8'hF0);
      wr(8'h0B, 8'h00);
      wr(8'h04, 8'hA5);
      wr(8'h05, 8'h03);
      rd_chk("R2", 8'h05, 8'h03);
      wr(8'h05, 8'hFF);
      rd_chk("R2", 8'h05, 8'h0F);
      wr(8'h05, 8'h03);
      wr(8'h01, 8'h77);
      rd_chk("R2", 8'h01, 8'h00);
      wr(8'h1F, 8'h5A);
      rd_chk("R2", 8'h1F, 8'h00);
      rd_chk("R2", 8'h0A, 8'hF0);

      // R3 / R4: channel 1 strobed
      @(negedge clk);
      pin_i = 12'h6C3; strb_i = 4'b1101;
      wait_cyc(4);
      @(posedge clk); #5;
      chk("R3", "pin_oe", pin_oe, 12'h0F0);
      chk("R3", "pin_o[7:4]", pin_o[7:4], 4'hA);
      @(negedge clk);
      strb_i = 4'b1111;
      wait_cyc(3);
      rd_chk("R4", 8'h04, 8'hA3);
      rd_chk("R4", 8'h05, 8'h06);

      // R5: no strobe, pins change, nothing captured
      @(negedge clk);
      pin_i = 12'h000;
      wait_cyc(4);
      rd_chk("R5", 8'h04, 8'hA3);
      chk("R5", "pin_oe", pin_oe, 12'h000);

      // R6: channels 0 and 2 both low
      @(negedge clk);
      pin_i = 12'h123; strb_i = 4'b1010;
      wait_cyc(5);
      @(negedge clk);
      strb_i = 4'b1111;
      wait_cyc(3);
      rd_chk("R6", 8'h02, 8'h03);
      rd_chk("R6", 8'h03, 8'h01);
      rd_chk("R6", 8'h06, 8'h00);

      // R7: two-flop latency on the strobe path
      @(negedge clk);
      strb_i = 4'b0111;
      @(posedge clk); #5;
      chk("R7", "pin_oe after 1 edge", pin_oe, 12'h000);
      @(posedge clk); #5;
      chk("R7", "pin_oe after 2 edges", pin_oe, 12'h0F0);
      wait_cyc(3);

      // R8: host write during live capture on channel 3
      @(negedge clk);
      addr = 8'h08; wdata = 8'h55; wr_en = 1'b1;
      @(posedge clk); #5;
      chk("R8", "write wins", rdata, 8'h55);
      @(negedge clk);
      wr_en = 1'b0;
      @(posedge clk); #5;
      chk("R8", "capture resumes", rdata, 8'h53);
      @(negedge clk);
      strb_i = 4'b1111;
      wait_cyc(3);

      // R9: static mode
      wr(8'h06, 8'h02);
      @(negedge clk);
      strb_i = 4'b0100;
      wr(8'h00, 8'h13);
      wait_cyc(4);
      @(posedge clk); #5;
      chk("R9", "strb_oe", strb_oe, 4'b0011);
      chk("R9", "strb_o[1:0]", strb_o[1:0], 2'b10);
      chk("R9", "pin_oe", pin_oe, 12'h000);
      rd_chk("R9", 8'h06, 8'h06);
      @(negedge clk);
      pin_i = 12'hFFF;
      wait_cyc(4);
      rd_chk("R9", 8'h02, 8'h03);

      // R10: back to strobed mode
      wr(8'h00, 8'h03);
      @(negedge clk);
      strb_i = 4'b1111;
      wait_cyc(3);
      @(posedge clk); #5;
      chk("R10", "strb_oe", strb_oe, 4'h0);
      rd_chk("R10", 8'h00, 8'h03);

      wait_cyc(2);
      finish_run();
   end
endmodule